// File: doc/BRIEF.md
# Dual Timer/Counter Unit

This peripheral provides two 16-bit counting channels on a byte-wide register bus. Each channel counts either machine cycles or falling edges seen on its own count pin. A machine cycle is one twelfth of the system clock rate. Software selects a per-channel mode from a mode register:

- 13-bit counting
- full 16-bit counting
- 8-bit counting with automatic reload
- split/stop

A control register holds the two run bits and the two overflow flags. The flags are also driven on a dedicated output pair.

The split mode couples the two channels. When channel 0 uses it, channel 0 becomes two free 8-bit counters. The upper one of these takes over channel 1's run bit and overflow flag. Channel 1 then keeps counting in its own mode without needing its run bit, and it raises no flag. When channel 1 itself is put in the split setting, it freezes.

A write to a counting byte in the same cycle as an increment takes precedence over that increment. Register reads return data one clock after the address is presented.

Top module: `dual_tmr_unit`

## Requirements
- R1: A free-running prescaler produces one machine tick every 12 clocks. The first tick is at the 12th rising edge after reset is released. A channel in timer mode advances by one at each tick while it is enabled. The run bits do not affect the prescaler.
- R2: In counter mode (C/T bit = 1), the count pin passes through two synchronizing flops and is sampled at each machine tick. The channel advances at the tick where the sampled level goes from 1 to 0. An input level must therefore be held for at least one machine cycle to be seen.
- R3: The mode register (address 0x89) holds channel 0 in bits [3:0] and channel 1 in bits [7:4]. Within each nibble, bit 3 is the gate, bit 2 is C/T, and bits [1:0] are the mode: 00 = 13-bit, 01 = 16-bit, 10 = auto-reload, 11 = split/stop. With the gate bit set, the channel counts only while its synchronized gate pin is high.
- R4: In 13-bit mode, the count is {high byte, low byte[4:0]} and wraps from 0x1FFF to 0 with an overflow. Bits [7:5] of the low byte read 0 after any increment. A write to the low byte in this mode stores only bits [4:0].
- R5: In auto-reload mode, only the low byte counts. When it is at 0xFF and advances, it takes the high byte's value and an overflow is raised. The high byte is left unchanged.
- R6: In 16-bit mode, the count {high, low} wraps from 0xFFFF to 0x0000 and raises an overflow.
- R7: The control register is at 0x88. Bit 4 is channel 0's run bit and bit 6 is channel 1's run bit. A channel with its run bit at 0 does not count, except in the case covered by R11. Bits [3:0] of the control register read as 0.
- R8: Bit 5 of the control register is flag 0 and bit 7 is flag 1. An overflow sets the matching flag. A control write loads both flags from the written data, and this write wins over a set in the same cycle. ovf_flag[1:0] always equals {flag 1, flag 0}.
- R9: Channel 1 in mode 11 holds its low and high bytes unchanged, except when they are written.
- R10: Channel 0 in mode 11 acts as two 8-bit counters. The low byte obeys run bit 0, gate 0 and C/T 0, and sets flag 0 when it wraps. The high byte counts machine ticks while run bit 1 is set, and sets flag 1 when it wraps.
- R11: While channel 0 is in mode 11, channel 1 counts in its own mode whatever its run bit is, with its gate still applied. Its overflows then set no flag.
- R12: Count bytes are at 0x8A (low 0), 0x8B (low 1), 0x8C (high 0) and 0x8D (high 1). bus_rdata shows the register at the address presented one clock earlier, and 0 for any other address. All registers are 0 after reset.
- R13: A bus write to a channel's low or high byte in the same cycle as that channel's increment stores the written value, and the increment is dropped. In split mode, only the half that was written loses its increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cnt_pin | input | 2 | External count inputs, one per channel |
| gate_pin | input | 2 | External gate enables, one per channel |
| ovf_flag | output | 2 | Overflow flags {channel 1, channel 0} |

## Verification
A write lands at the rising edge where it is presented, and bus_rdata shows the addressed register one edge after the address. A timer increment lands at the tick edge, which is the 12th edge after reset and every 12th edge after that. A pin fall is counted no sooner than two synchronizer edges after it occurs, and only at the following tick. An overflow flag shows on ovf_flag at the same edge as the wrap that caused it. The bench steps a behavioural model at every rising edge with the same inputs, including the synchronizer delay and the tick phase. It then compares bus_rdata and ovf_flag at each falling edge, while the address cycles through all six registers. Because of this, every due cycle listed above is checked exactly, not inside a window.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int BYTE_W = 8;
  localparam int LO13_W = 5;

  localparam logic [7:0] ADDR_CTRL = 8'h88;
  localparam logic [7:0] ADDR_MODE = 8'h89;
  localparam logic [7:0] ADDR_LO0  = 8'h8A;
  localparam logic [7:0] ADDR_LO1  = 8'h8B;
  localparam logic [7:0] ADDR_HI0  = 8'h8C;
  localparam logic [7:0] ADDR_HI1  = 8'h8D;

  // control register bit positions
  localparam int RUN0_BIT  = 4;
  localparam int FLAG0_BIT = 5;
  localparam int RUN1_BIT  = 6;
  localparam int FLAG1_BIT = 7;

  // mode nibble bit positions
  localparam int CT_BIT   = 2;
  localparam int GATE_BIT = 3;

  typedef enum logic [1:0] {
    MD_13     = 2'b00,
    MD_16     = 2'b01,
    MD_RELOAD = 2'b10,
    MD_SPLIT  = 2'b11
  } tmode_e;
endpackage

// File: rtl/dtmr_prescale.sv
module dtmr_prescale #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = $clog2(DIV);

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/dtmr_pin_sync.sv
module dtmr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic cnt_in,
  input  logic gate_in,
  output logic fall,
  output logic gate_lvl
);
  logic [STAGES-1:0] csh;
  logic [STAGES-1:0] gsh;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      csh  <= '0;
      gsh  <= '0;
      last <= 1'b0;
    end else begin
      csh <= {csh[STAGES-2:0], cnt_in};
      gsh <= {gsh[STAGES-2:0], gate_in};
      if (tick) last <= csh[STAGES-1];
    end
  end

  assign fall     = tick & last & ~csh[STAGES-1];
  assign gate_lvl = gsh[STAGES-1];
endmodule

// File: rtl/dtmr_counter.sv
module dtmr_counter
  import dtmr_pkg::*;
#(
  parameter bit SPLIT_OK = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  tmode_e            mode,
  input  logic              inc_lo,
  input  logic              inc_hi,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] tl,
  output logic [BYTE_W-1:0] th,
  output logic              ovf_lo,
  output logic              ovf_hi
);
  localparam int W13 = BYTE_W + LO13_W;
  localparam int W16 = 2 * BYTE_W;

  logic [BYTE_W-1:0] tl_n, th_n;
  logic [W13-1:0]    v13;
  logic [W16-1:0]    v16;
  logic              blk;

  assign v13 = {th, tl[LO13_W-1:0]} + W13'(1);
  assign v16 = {th, tl} + W16'(1);
  assign blk = wr_lo | wr_hi;

  always_comb begin
    tl_n   = tl;
    th_n   = th;
    ovf_lo = 1'b0;
    ovf_hi = 1'b0;
    unique case (mode)
      MD_13: if (inc_lo && !blk) begin
        ovf_lo = &{th, tl[LO13_W-1:0]};
        tl_n   = {{(BYTE_W-LO13_W){1'b0}}, v13[LO13_W-1:0]};
        th_n   = v13[W13-1:LO13_W];
      end
      MD_16: if (inc_lo && !blk) begin
        ovf_lo = &{th, tl};
        {th_n, tl_n} = v16;
      end
      MD_RELOAD: if (inc_lo && !blk) begin
        ovf_lo = &tl;
        tl_n   = (&tl) ? th : tl + 1'b1;
      end
      MD_SPLIT: if (SPLIT_OK) begin
        if (inc_lo && !wr_lo) begin
          ovf_lo = &tl;
          tl_n   = tl + 1'b1;
        end
        if (inc_hi && !wr_hi) begin
          ovf_hi = &th;
          th_n   = th + 1'b1;
        end
      end
    endcase
    if (wr_lo) tl_n = (mode == MD_13) ? {{(BYTE_W-LO13_W){1'b0}}, wdata[LO13_W-1:0]} : wdata;
    if (wr_hi) th_n = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tl <= '0;
      th <= '0;
    end else begin
      tl <= tl_n;
      th <= th_n;
    end
  end

  // R4
  mode13_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_13 && inc_lo && !blk) |=> (tl[BYTE_W-1:LO13_W] == '0));

  // R5
  reload_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_RELOAD && inc_lo && tl == '1 && !blk) |=> (tl == $past(th)));

  // R9
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (SPLIT_OK == 1'b0 && mode == MD_SPLIT && !blk) |=> (tl == $past(tl) && th == $past(th)));
endmodule

// File: rtl/dual_tmr_unit.sv
module dual_tmr_unit
  import dtmr_pkg::*;
#(
  parameter int PRESCALE    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_wr,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [1:0] cnt_pin,
  input  logic [1:0] gate_pin,
  output logic [1:0] ovf_flag
);
  localparam int NCH = 2;

  logic              tick;
  logic [7:0]        mode_r;
  logic [NCH-1:0]    run_r, flag_r;
  logic [NCH-1:0]    fall, gate_lvl, gate_ok, run_ok, inc_lo, inc_hi;
  logic [NCH-1:0]    wr_lo, wr_hi, ovl, ovh;
  logic [BYTE_W-1:0] tl_q [NCH];
  logic [BYTE_W-1:0] th_q [NCH];
  tmode_e            md [NCH];
  logic              split0, wr_ctrl, wr_mode;
  logic [NCH-1:0]    flag_set;

  dtmr_prescale #(.DIV(PRESCALE)) u_pre (.clk(clk), .rst(rst), .tick(tick));

  assign split0  = (md[0] == MD_SPLIT);
  assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_mode = bus_wr && (bus_addr == ADDR_MODE);
  assign wr_lo   = {bus_wr && bus_addr == ADDR_LO1, bus_wr && bus_addr == ADDR_LO0};
  assign wr_hi   = {bus_wr && bus_addr == ADDR_HI1, bus_wr && bus_addr == ADDR_HI0};
  assign run_ok  = {split0 | run_r[1], run_r[0]};
  assign inc_hi  = {1'b0, split0 & run_r[1] & tick};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign md[i]      = tmode_e'(mode_r[4*i +: 2]);
    assign gate_ok[i] = ~mode_r[4*i + GATE_BIT] | gate_lvl[i];
    assign inc_lo[i]  = run_ok[i] & gate_ok[i] & (mode_r[4*i + CT_BIT] ? fall[i] : tick);

    dtmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .tick(tick),
      .cnt_in(cnt_pin[i]), .gate_in(gate_pin[i]),
      .fall(fall[i]), .gate_lvl(gate_lvl[i])
    );

    dtmr_counter #(.SPLIT_OK(i == 0)) u_cnt (
      .clk(clk), .rst(rst), .mode(md[i]),
      .inc_lo(inc_lo[i]), .inc_hi(inc_hi[i]),
      .wr_lo(wr_lo[i]), .wr_hi(wr_hi[i]), .wdata(bus_wdata),
      .tl(tl_q[i]), .th(th_q[i]), .ovf_lo(ovl[i]), .ovf_hi(ovh[i])
    );
  end

  assign flag_set = {split0 ? ovh[0] : ovl[1], ovl[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_r    <= '0;
      run_r     <= '0;
      flag_r    <= '0;
      bus_rdata <= '0;
    end else begin
      if (wr_ctrl) begin
        run_r  <= {bus_wdata[RUN1_BIT], bus_wdata[RUN0_BIT]};
        flag_r <= {bus_wdata[FLAG1_BIT], bus_wdata[FLAG0_BIT]};
      end else begin
        flag_r <= flag_r | flag_set;
      end
      if (wr_mode) mode_r <= bus_wdata;
      unique case (bus_addr)
        ADDR_CTRL: bus_rdata <= {flag_r[1], run_r[1], flag_r[0], run_r[0], 4'b0000};
        ADDR_MODE: bus_rdata <= mode_r;
        ADDR_LO0:  bus_rdata <= tl_q[0];
        ADDR_LO1:  bus_rdata <= tl_q[1];
        ADDR_HI0:  bus_rdata <= th_q[0];
        ADDR_HI1:  bus_rdata <= th_q[1];
        default:   bus_rdata <= '0;
      endcase
    end
  end

  assign ovf_flag = flag_r;

  // R8
  flag0_set_chk: assert property (@(posedge clk) disable iff (rst)
    (ovl[0] && !wr_ctrl) |=> ovf_flag[0]);

  // R7
  run0_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_r[0] && !wr_lo[0]) |=> (tl_q[0] == $past(tl_q[0])));
endmodule

// File: tb/test_dual_tmr_unit.sv
module test_dual_tmr_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h88;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [1:0] cnt_pin = 2'b00;
  logic [1:0] gate_pin = 2'b00;
  logic [1:0] ovf_flag;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  int    rot = 0;
  bit    armed = 1'b0;
  string req = "R12";

  dual_tmr_unit i_dual_tmr_unit (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_pin(cnt_pin), .gate_pin(gate_pin), .ovf_flag(ovf_flag)
  );

  always #5 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int         m_tl [2];
  int         m_th [2];
  logic [7:0] m_mode, m_rd;
  logic [1:0] m_tr, m_tf, m_cs1, m_cs2, m_gs1, m_gs2, m_last;
  int         m_ph;

  task automatic chan(input int i, input int md, input bit ev, input bit evh,
                      input bit sok, output bit olo, output bit ohi);
    int v;
    bit wl, wh;
    wl  = bus_wr && bus_addr == ((i == 0) ? 8'h8A : 8'h8B);
    wh  = bus_wr && bus_addr == ((i == 0) ? 8'h8C : 8'h8D);
    olo = 1'b0;
    ohi = 1'b0;
    if (md == 3) begin
      if (sok) begin
        if (ev && !wl) begin
          olo = (m_tl[i] == 255);
          m_tl[i] = (m_tl[i] + 1) % 256;
        end
        if (evh && !wh) begin
          ohi = (m_th[i] == 255);
          m_th[i] = (m_th[i] + 1) % 256;
        end
      end
    end else if (ev && !wl && !wh) begin
      if (md == 0) begin
        v = m_th[i] * 32 + (m_tl[i] % 32);
        olo = (v == 8191);
        v = (v + 1) % 8192;
        m_tl[i] = v % 32;
        m_th[i] = v / 32;
      end else if (md == 1) begin
        v = m_th[i] * 256 + m_tl[i];
        olo = (v == 65535);
        v = (v + 1) % 65536;
        m_tl[i] = v % 256;
        m_th[i] = v / 256;
      end else begin
        if (m_tl[i] == 255) begin
          olo = 1'b1;
          m_tl[i] = m_th[i];
        end else m_tl[i] = m_tl[i] + 1;
      end
    end
    if (wl) m_tl[i] = (md == 0) ? int'(bus_wdata) % 32 : int'(bus_wdata);
    if (wh) m_th[i] = int'(bus_wdata);
  endtask

  always @(posedge clk) begin
    bit tick, split, ev0, ev1, evh, o0l, o0h, o1l, o1h;
    bit [1:0] fall, gok;
    int md0, md1;
    if (rst) begin
      for (int i = 0; i < 2; i++) begin m_tl[i] = 0; m_th[i] = 0; end
      m_mode = 0; m_rd = 0; m_tr = 0; m_tf = 0;
      m_cs1 = 0; m_cs2 = 0; m_gs1 = 0; m_gs2 = 0; m_last = 0; m_ph = 0;
    end else begin
      case (bus_addr)
        8'h88:   m_rd = {m_tf[1], m_tr[1], m_tf[0], m_tr[0], 4'b0000};
        8'h89:   m_rd = m_mode;
        8'h8A:   m_rd = 8'(m_tl[0]);
        8'h8B:   m_rd = 8'(m_tl[1]);
        8'h8C:   m_rd = 8'(m_th[0]);
        8'h8D:   m_rd = 8'(m_th[1]);
        default: m_rd = 8'h00;
      endcase
      tick = (m_ph == 11);
      for (int i = 0; i < 2; i++) begin
        fall[i] = tick && m_last[i] && !m_cs2[i];
        gok[i]  = !m_mode[4*i+3] || m_gs2[i];
        if (tick) m_last[i] = m_cs2[i];
      end
      md0   = int'(m_mode[1:0]);
      md1   = int'(m_mode[5:4]);
      split = (md0 == 3);
      ev0 = m_tr[0] && gok[0] && (m_mode[2] ? fall[0] : tick);
      ev1 = (split || m_tr[1]) && gok[1] && (m_mode[6] ? fall[1] : tick);
      evh = split && m_tr[1] && tick;
      chan(0, md0, ev0, evh, 1'b1, o0l, o0h);
      chan(1, md1, ev1, 1'b0, 1'b0, o1l, o1h);
      if (bus_wr && bus_addr == 8'h88) begin
        m_tr = {bus_wdata[6], bus_wdata[4]};
        m_tf = {bus_wdata[7], bus_wdata[5]};
      end else begin
        m_tf = m_tf | {split ? o0h : o1l, o0l};
      end
      if (bus_wr && bus_addr == 8'h89) m_mode = bus_wdata;
      m_cs2 = m_cs1; m_cs1 = cnt_pin;
      m_gs2 = m_gs1; m_gs1 = gate_pin;
      m_ph  = (m_ph + 1) % 12;
    end
  end

  // ---------------- checking ----------------
  task automatic check8(input string r, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%02h expected=%02h at cycle %0d", r, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (armed && !rst) begin
      check8(req, "bus_rdata", bus_rdata, m_rd);
      check8(req, "ovf_flag", {6'b0, ovf_flag}, {6'b0, m_tf});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      bus_wr = 1'b0;
      bus_addr = 8'h88 + 8'(rot % 6);
      rot++;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 R8: reset state
    check8("R12", "reset rdata", bus_rdata, 8'h00);
    check8("R8", "reset flags", {6'b0, ovf_flag}, 8'h00);
    #1 rst = 1'b0;
    armed = 1'b1;

    req = "R1";  wr(8'h89, 8'h11); wr(8'h88, 8'h50); idle(80);
    req = "R7";  wr(8'h88, 8'h10); idle(40);
    req = "R12"; wr(8'h88, 8'h1F); idle(12); wr(8'h88, 8'h10);
    req = "R6";  wr(8'h8C, 8'hFF); wr(8'h8A, 8'hFC); idle(70);
    req = "R8";  wr(8'h88, 8'h10); idle(14);
    req = "R13"; for (int k = 0; k < 13; k++) wr(8'h8A, 8'h20); idle(30);
    req = "R4";  wr(8'h89, 8'h10); wr(8'h8A, 8'hFF); wr(8'h8C, 8'hFF); idle(40);
    wr(8'h8A, 8'hE3); idle(30);
    req = "R5";  wr(8'h89, 8'h12); wr(8'h8C, 8'hF0); wr(8'h8A, 8'hFD); idle(300);
    req = "R2";  wr(8'h88, 8'h10); wr(8'h89, 8'h15); wr(8'h8C, 8'h00); wr(8'h8A, 8'hFD);
    for (int k = 0; k < 6; k++) begin
      cnt_pin[0] = 1'b1; idle(30);
      cnt_pin[0] = 1'b0; idle(30);
    end
    cnt_pin[0] = 1'b1; idle(2); cnt_pin[0] = 1'b0; idle(30);
    req = "R3";  wr(8'h89, 8'h19); gate_pin[0] = 1'b0; idle(50);
    gate_pin[0] = 1'b1; idle(50); gate_pin[0] = 1'b0; idle(30);
    req = "R9";  wr(8'h89, 8'h31); wr(8'h88, 8'h50); idle(60);
    wr(8'h8B, 8'h44); idle(30);
    req = "R11"; wr(8'h88, 8'h10); wr(8'h89, 8'h13);
    wr(8'h8D, 8'hFF); wr(8'h8B, 8'hF8); wr(8'h8A, 8'hF0); idle(200);
    req = "R10"; wr(8'h88, 8'h50); wr(8'h8C, 8'hF8); idle(220);
    wr(8'h88, 8'h00); idle(30);
    req = "R13"; wr(8'h88, 8'h50);
    for (int k = 0; k < 13; k++) wr(8'h8C, 8'h10);
    idle(40);
    req = "R8";  wr(8'h88, 8'hA0); idle(20);
    idle(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule